// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the processor's system control state and is reached through coprocessor move instructions. A decoded move-to-coprocessor instruction drives the write port with a register number, an operation code and a data word. A decoded move-from-coprocessor instruction drives the read port with a register number and an operation code. It gets back a data word in the same cycle.

Four storage registers are held: system control, page table base, fault status and fault address. Register 0 is read-only. It gives back two words that are fixed by parameters: the CPU identity word and the cache geometry word. Writes to register 5 are not stored. They are decoded into one-cycle cache maintenance pulses, one output for each operation. For the three single-line operations, the written word is also presented as the line address. Writes to register 6 with an accepted operation code become a single TLB invalidate pulse. Any access whose register and operation code pair is not supported is rejected. It changes no state and raises an error pulse.

Top module: `sysctl_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, registers 1 to 4 clear to zero. In the cycle after a reset edge, every command pulse and `acc_err` are low, and `line_addr` is zero.
- R2: A write to register 1, 2, 3 or 4 with operation code 0 stores `wr_data`. A read of the same register with operation code 0 returns it from the next cycle on.
- R3: A read of register 0 returns `ID_WORD` with operation code 0 and `CTYPE_WORD` with operation code 1. Every write to register 0 is rejected.
- R4: An access to registers 1 to 4 with a non-zero operation code is rejected. A read returns zero, and a write leaves all four registers unchanged.
- R5: A write to register 5 with operation code 28, 20, 12, 10 or 14 pulses, in the next cycle, `ic_dc_inv_all`, `ic_inv_all`, `dc_inv_all`, `dc_clean_all` or `dc_flush_all` respectively.
- R6: A write to register 5 with operation code 13, 11 or 15 pulses `dc_inv_line`, `dc_clean_line` or `dc_flush_line` respectively in the next cycle. In that cycle `line_addr` equals the written word, and it holds that value until the next line operation. A write to register 5 with any other operation code is rejected.
- R7: A write to register 6 with operation code 2 to 6 inclusive pulses `tlb_inv_all` in the next cycle. Any other operation code on register 6 is rejected.
- R8: A read of register 5, of register 6, of any register number above 6, or of register 0 with an operation code other than 0 or 1 returns zero and is rejected. Writes to register numbers above 6 are rejected.
- R9: At most one of the nine command outputs is high in any cycle. Each one is high only in the cycle directly after its write.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value held before the write.
- R11: `acc_err` is high for exactly the cycle after a cycle that had a rejected read, a rejected write, or both. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write access this cycle |
| wr_reg | input | REG_W | Write register number |
| wr_op | input | OP_W | Write operation code |
| wr_data | input | DATA_W | Write data or line address |
| rd_en | input | 1 | Read access this cycle |
| rd_reg | input | REG_W | Read register number |
| rd_op | input | OP_W | Read operation code |
| rd_data | output | DATA_W | Read result, combinational |
| acc_err | output | 1 | Rejected-access pulse |
| ic_dc_inv_all | output | 1 | Invalidate all instruction and data cache |
| ic_inv_all | output | 1 | Invalidate all instruction cache |
| dc_inv_all | output | 1 | Invalidate all data cache |
| dc_clean_all | output | 1 | Clean all data cache |
| dc_flush_all | output | 1 | Clean and invalidate all data cache |
| dc_inv_line | output | 1 | Invalidate one data cache line |
| dc_clean_line | output | 1 | Clean one data cache line |
| dc_flush_line | output | 1 | Clean and invalidate one data cache line |
| tlb_inv_all | output | 1 | Invalidate the whole TLB |
| line_addr | output | DATA_W | Address for the line operations |

## Verification
The read port and the write port work on their own, so in a single cycle a read can see a register while a write updates it. In the same cycle, a rejected read and a rejected write can also both request the single error pulse. Random stimulus sets both enables often and draws the register numbers from a small range, so these collisions are common. Directed vectors also force a read and a write to the same register, and a pair of rejected accesses, in the same cycle. The bench expects the value from before the write on `rd_data`, and exactly one `acc_err` cycle.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 5,
  parameter logic [DATA_W-1:0] ID_WORD    = DATA_W'(32'h4D11_0863),
  parameter logic [DATA_W-1:0] CTYPE_WORD = DATA_W'(32'h0D15_2152)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic [OP_W-1:0]   rd_op,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic              ic_dc_inv_all,
  output logic              ic_inv_all,
  output logic              dc_inv_all,
  output logic              dc_clean_all,
  output logic              dc_flush_all,
  output logic              dc_inv_line,
  output logic              dc_clean_line,
  output logic              dc_flush_line,
  output logic              tlb_inv_all,
  output logic [DATA_W-1:0] line_addr
);

  localparam logic [REG_W-1:0] N_ID    = REG_W'(0);
  localparam logic [REG_W-1:0] N_CTL   = REG_W'(1);
  localparam logic [REG_W-1:0] N_PTB   = REG_W'(2);
  localparam logic [REG_W-1:0] N_FST   = REG_W'(3);
  localparam logic [REG_W-1:0] N_FAD   = REG_W'(4);
  localparam logic [REG_W-1:0] N_CACHE = REG_W'(5);
  localparam logic [REG_W-1:0] N_TLB   = REG_W'(6);

  localparam logic [OP_W-1:0] OP_PLAIN   = OP_W'(0);
  localparam logic [OP_W-1:0] OP_CTYPE   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_IDINV   = OP_W'(28);
  localparam logic [OP_W-1:0] OP_IINV    = OP_W'(20);
  localparam logic [OP_W-1:0] OP_DINV    = OP_W'(12);
  localparam logic [OP_W-1:0] OP_DCLN    = OP_W'(10);
  localparam logic [OP_W-1:0] OP_DFLS    = OP_W'(14);
  localparam logic [OP_W-1:0] OP_LINV    = OP_W'(13);
  localparam logic [OP_W-1:0] OP_LCLN    = OP_W'(11);
  localparam logic [OP_W-1:0] OP_LFLS    = OP_W'(15);
  localparam logic [OP_W-1:0] OP_TLB_LO  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_TLB_HI  = OP_W'(6);

  logic [DATA_W-1:0] ctl_q, ptb_q, fst_q, fad_q;

  wire wr_plain = wr_op == OP_PLAIN;
  wire wr_ctl   = wr_en && wr_reg == N_CTL && wr_plain;
  wire wr_ptb   = wr_en && wr_reg == N_PTB && wr_plain;
  wire wr_fst   = wr_en && wr_reg == N_FST && wr_plain;
  wire wr_fad   = wr_en && wr_reg == N_FAD && wr_plain;
  wire wr_cache = wr_en && wr_reg == N_CACHE;

  logic [7:0] cop;
  assign cop[0] = wr_cache && wr_op == OP_IDINV;
  assign cop[1] = wr_cache && wr_op == OP_IINV;
  assign cop[2] = wr_cache && wr_op == OP_DINV;
  assign cop[3] = wr_cache && wr_op == OP_DCLN;
  assign cop[4] = wr_cache && wr_op == OP_DFLS;
  assign cop[5] = wr_cache && wr_op == OP_LINV;
  assign cop[6] = wr_cache && wr_op == OP_LCLN;
  assign cop[7] = wr_cache && wr_op == OP_LFLS;

  wire tlb_hit = wr_en && wr_reg == N_TLB && wr_op >= OP_TLB_LO && wr_op <= OP_TLB_HI;
  wire wr_ok   = wr_ctl || wr_ptb || wr_fst || wr_fad || (|cop) || tlb_hit;

  logic rd_ok;
  always_comb begin
    rd_data = '0;
    rd_ok   = 1'b0;
    if (rd_reg == N_ID) begin
      if (rd_op == OP_PLAIN) begin rd_data = ID_WORD;    rd_ok = 1'b1; end
      if (rd_op == OP_CTYPE) begin rd_data = CTYPE_WORD; rd_ok = 1'b1; end
    end else if (rd_op == OP_PLAIN) begin
      rd_ok = 1'b1;
      case (rd_reg)
        N_CTL:   rd_data = ctl_q;
        N_PTB:   rd_data = ptb_q;
        N_FST:   rd_data = fst_q;
        N_FAD:   rd_data = fad_q;
        default: rd_ok   = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ptb_q <= '0;
      fst_q <= '0;
      fad_q <= '0;
      line_addr <= '0;
      acc_err <= 1'b0;
      {dc_flush_line, dc_clean_line, dc_inv_line, dc_flush_all,
       dc_clean_all, dc_inv_all, ic_inv_all, ic_dc_inv_all} <= '0;
      tlb_inv_all <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data;
      if (wr_ptb) ptb_q <= wr_data;
      if (wr_fst) fst_q <= wr_data;
      if (wr_fad) fad_q <= wr_data;
      if (|cop[7:5]) line_addr <= wr_data;
      {dc_flush_line, dc_clean_line, dc_inv_line, dc_flush_all,
       dc_clean_all, dc_inv_all, ic_inv_all, ic_dc_inv_all} <= cop;
      tlb_inv_all <= tlb_hit;
      acc_err <= (wr_en && !wr_ok) || (rd_en && !rd_ok);
    end
  end

endmodule

module sysctl_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_reg,
  input logic [OP_W-1:0]   wr_op,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [REG_W-1:0]  rd_reg,
  input logic [OP_W-1:0]   rd_op,
  input logic [DATA_W-1:0] rd_data,
  input logic              acc_err,
  input logic [8:0]        cmds,
  input logic [DATA_W-1:0] line_addr
);

  wire line_pulse = |cmds[7:5];

  // R1
  after_reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (cmds == '0 && !acc_err && line_addr == '0));

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmds));

  // R5
  cache_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    (|cmds[7:0]) |-> $past(wr_en && wr_reg == REG_W'(5)));

  // R6
  line_addr_chk: assert property (@(posedge clk) disable iff (rst)
    line_pulse |-> line_addr == $past(wr_data));

  // R7
  tlb_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmds[8] |-> $past(wr_en && wr_reg == REG_W'(6) && wr_op >= OP_W'(2) && wr_op <= OP_W'(6)));

  // R4
  bad_op_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_reg >= REG_W'(1) && wr_reg <= REG_W'(4) && wr_op != '0) |=> acc_err);

  // R8
  unsupported_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_reg >= REG_W'(5)) |-> (rd_data == '0));

  // R11
  err_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(wr_en || rd_en));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_pulse && !$past(rst)) |-> $stable(line_addr));

  wire unused_ok = ^{rd_op};

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .wr_op(wr_op), .wr_data(wr_data),
  .rd_en(rd_en), .rd_reg(rd_reg), .rd_op(rd_op), .rd_data(rd_data), .acc_err(acc_err),
  .cmds({tlb_inv_all, dc_flush_line, dc_clean_line, dc_inv_line, dc_flush_all,
         dc_clean_all, dc_inv_all, ic_inv_all, ic_dc_inv_all}),
  .line_addr(line_addr)
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  localparam int DW = 32, RW = 4, OW = 5;
  localparam logic [DW-1:0] IDW = 32'h4D11_0863, CTW = 32'h0D15_2152;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [RW-1:0] wr_reg = 0, rd_reg = 0;
  logic [OW-1:0] wr_op = 0, rd_op = 0;
  logic [DW-1:0] wr_data = 0, rd_data, line_addr;
  logic acc_err, c0, c1, c2, c3, c4, c5, c6, c7, tlb;

  sysctl_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .wr_op(wr_op), .wr_data(wr_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .rd_op(rd_op), .rd_data(rd_data), .acc_err(acc_err),
    .ic_dc_inv_all(c0), .ic_inv_all(c1), .dc_inv_all(c2), .dc_clean_all(c3), .dc_flush_all(c4),
    .dc_inv_line(c5), .dc_clean_line(c6), .dc_flush_line(c7), .tlb_inv_all(tlb),
    .line_addr(line_addr));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] m [1:4];
  logic [DW-1:0] m_line;

  function automatic logic [8:0] exp_cmd(bit we, int r, int op);
    logic [8:0] v = '0;
    if (we && r == 5) case (op)
      28: v[0] = 1; 20: v[1] = 1; 12: v[2] = 1; 10: v[3] = 1; 14: v[4] = 1;
      13: v[5] = 1; 11: v[6] = 1; 15: v[7] = 1; default: ;
    endcase
    if (we && r == 6 && op >= 2 && op <= 6) v[8] = 1;
    return v;
  endfunction

  function automatic bit wr_legal(int r, int op);
    return (r >= 1 && r <= 4 && op == 0) || exp_cmd(1, r, op) != 0;
  endfunction

  function automatic bit rd_legal(int r, int op);
    return (r == 0 && op <= 1) || (r >= 1 && r <= 4 && op == 0);
  endfunction

  function automatic logic [DW-1:0] rd_exp(int r, int op);
    if (r == 0 && op == 0) return IDW;
    if (r == 0 && op == 1) return CTW;
    if (r >= 1 && r <= 4 && op == 0) return m[r];
    return '0;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic vec(bit we, int wr, int wo, logic [DW-1:0] wd, bit re, int rr, int ro, string tag);
    logic [8:0] ec;
    bit ee;
    @(negedge clk);
    wr_en = we; wr_reg = RW'(wr); wr_op = OW'(wo); wr_data = wd;
    rd_en = re; rd_reg = RW'(rr); rd_op = OW'(ro);
    #1;
    chk({tag, " read (R2 R3 R4 R8 R10)"}, rd_data, rd_exp(rr, ro));
    ec = exp_cmd(we, wr, wo);
    ee = (we && !wr_legal(wr, wo)) || (re && !rd_legal(rr, ro));
    if (we && wr >= 1 && wr <= 4 && wo == 0) m[wr] = wd;
    if (ec[7:5] != 0) m_line = wd;
    @(posedge clk); #1;
    chk({tag, " cmds (R5 R6 R7 R9)"}, DW'({tlb, c7, c6, c5, c4, c3, c2, c1, c0}), DW'(ec));
    chk({tag, " err (R11)"}, DW'(acc_err), DW'(ee));
    chk({tag, " line_addr (R6)"}, line_addr, m_line);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 1; i <= 4; i++) m[i] = '0;
    m_line = '0;
    // dirty state, then reset to confirm it clears
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    vec(1, 3, 0, 32'hDEAD_BEEF, 0, 0, 0, "pre");
    vec(1, 5, 13, 32'h1234_5670, 0, 0, 0, "pre");
    @(negedge clk); rst = 1; wr_en = 0; rd_en = 0;
    @(posedge clk); #1;
    for (int i = 1; i <= 4; i++) m[i] = '0;
    m_line = '0;
    chk("R1 err after reset", DW'(acc_err), 0);
    chk("R1 cmds after reset", DW'({tlb, c7, c6, c5, c4, c3, c2, c1, c0}), 0);
    chk("R1 line_addr after reset", line_addr, 0);
    @(negedge clk); rst = 0;
    rd_reg = 3; rd_op = 0; #1;
    chk("R1 reg3 cleared", rd_data, 0);

    // directed
    vec(0, 0, 0, 0, 1, 0, 0, "R3 id");
    vec(0, 0, 0, 0, 1, 0, 1, "R3 ctype");
    vec(1, 0, 0, 32'h5555_5555, 1, 0, 2, "R3 write id / R8 read op2");
    for (int r = 1; r <= 4; r++) vec(1, r, 0, 32'hA000_0000 + r, 1, r, 0, "R2 write");
    for (int r = 1; r <= 4; r++) vec(0, 0, 0, 0, 1, r, 0, "R2 readback");
    vec(1, 2, 1, 32'hFFFF_FFFF, 1, 2, 1, "R4 bad op");
    vec(0, 0, 0, 0, 1, 2, 0, "R4 unchanged");
    vec(1, 1, 0, 32'hCAFE_0001, 1, 1, 0, "R10 same cycle");
    vec(0, 0, 0, 0, 1, 1, 0, "R10 after");
    vec(1, 5, 28, 0, 0, 0, 0, "R5 op28");
    vec(1, 5, 20, 0, 0, 0, 0, "R5 op20");
    vec(1, 5, 12, 0, 0, 0, 0, "R5 op12");
    vec(1, 5, 10, 0, 0, 0, 0, "R5 op10");
    vec(1, 5, 14, 0, 0, 0, 0, "R5 op14");
    vec(1, 5, 13, 32'h0000_1040, 0, 0, 0, "R6 op13");
    vec(1, 5, 11, 32'h0000_2080, 0, 0, 0, "R6 op11");
    vec(1, 5, 15, 32'h0000_30C0, 0, 0, 0, "R6 op15");
    vec(1, 5, 15, 32'h0000_4100, 0, 0, 0, "R9 back to back");
    vec(1, 5, 16, 32'h0BAD_0BAD, 0, 0, 0, "R6 bad op");
    idle(); #1;
    chk("R9 pulse ends", DW'({tlb, c7, c6, c5, c4, c3, c2, c1, c0}), 0);
    vec(1, 6, 1, 0, 0, 0, 0, "R7 op1");
    vec(1, 6, 2, 0, 0, 0, 0, "R7 op2");
    vec(1, 6, 6, 0, 0, 0, 0, "R7 op6");
    vec(1, 6, 7, 0, 0, 0, 0, "R7 op7");
    vec(1, 7, 0, 32'h1, 1, 7, 0, "R8 reg7");
    vec(1, 15, 0, 32'h1, 1, 15, 0, "R8 reg15 R11 both bad");
    vec(0, 0, 0, 0, 1, 5, 13, "R8 read reg5");
    vec(0, 0, 0, 0, 1, 6, 2, "R8 read reg6");

    // random
    for (int n = 0; n < 3000; n++) begin
      int ops[14] = '{0, 1, 2, 6, 7, 10, 11, 12, 13, 14, 15, 20, 28, 3};
      int wr, wo, rr, ro;
      wr = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 7);
      rr = ($urandom_range(0, 3) == 0) ? wr : $urandom_range(0, 7);
      wo = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : ops[$urandom_range(0, 13)];
      ro = ($urandom_range(0, 1) == 0) ? 0 : ops[$urandom_range(0, 13)];
      vec($urandom_range(0, 2) != 0, wr, wo, $urandom, $urandom_range(0, 1) == 1, rr, ro, "rand");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule